// File: doc/BRIEF.md
# Fail-first vector load sequencer

This block walks a vector of scalar doubleword loads, one element at a time. For element i it reads address register RA+i, adds a sign-extended immediate offset, sends a single request to memory and waits for the response. It writes the returned doubleword to register RT+i. It then classifies the value against zero, producing a small condition nibble. If that value meets a chosen test, the loop ends early and the vector length is cut at that point.

The host issues a start command with the register bases, the offset, the vector length and three mode bits: condition write enable, inclusive truncation and the test bit. A one-cycle done pulse returns the final vector length. When no element matches, the length comes back unchanged. Register indices wrap modulo the register-file size.

Top module: `ffld_seq`

## Requirements
- R1: After reset, done, mem_req, rf_wr_en and cr_wr_en are all 0.
- R2: For element i, mem_addr equals the register-file content at index (start_ra+i) mod 128 plus start_off sign-extended from 16 bits. Elements are requested in ascending order from i=0.
- R3: In the cycle where a response is accepted for element i, rf_wr_en is 1, rf_wr_addr is (start_rt+i) mod 128 and rf_wr_data is the response data.
- R4: At most one memory request is outstanding. mem_req is a one-cycle pulse, and the next request comes no earlier than the cycle after the response.
- R5: The condition value is {LT,GT,EQ,SO} on bits 3..0. It comes from a signed compare of the loaded value with zero, and SO is 0. It is written, with cr_wr_idx = i, in the same cycle as the register write, but only when start_rc is 1.
- R6: When the EQ bit of element i equals start_tbit, the loop stops after that element with no further requests. done_vl is i+1 if start_vli is 1, else i.
- R7: If no element matches, all start_vl elements are loaded and done_vl equals start_vl.
- R8: A start with start_vl = 0 raises done one cycle later with done_vl = 0. It makes no memory request and no register or condition write.
- R9: A start pulse while a vector is in progress is ignored.
- R10: done is a one-cycle pulse. It rises in the cycle after the last accepted response, and no request is active while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start command pulse |
| start_ra | input | 7 | Address register base index |
| start_rt | input | 7 | Destination register base index |
| start_off | input | 16 | Signed address offset |
| start_vl | input | 8 | Vector length |
| start_rc | input | 1 | Enable condition-field writes |
| start_vli | input | 1 | Keep the matching element when truncating |
| start_tbit | input | 1 | EQ value that stops the loop |
| rf_rd_addr | output | 7 | Register-file read index |
| rf_rd_data | input | 64 | Register-file read data (same cycle) |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_addr | output | 7 | Register-file write index |
| rf_wr_data | output | 64 | Register-file write data |
| mem_req | output | 1 | Memory load request |
| mem_addr | output | 64 | Effective address |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_data | input | 64 | Memory response doubleword |
| cr_wr_en | output | 1 | Condition-field write enable |
| cr_wr_idx | output | 7 | Condition-field index |
| cr_wr_val | output | 4 | Condition value {LT,GT,EQ,SO} |
| done | output | 1 | Completion pulse |
| done_vl | output | 8 | Final vector length |

## Verification
The element counter drives every address, so a wrong count shows on mem_addr at the very next request. It shows on rf_wr_addr in the same cycle as the response. A broken stop decision shows in two ways within one cycle of the matching response: an extra request appears, or done_vl is off by one. A wrong state can also leave a second request open or drop the done pulse, and the bench's request/response pairing and done timeout catch both. Latencies of zero to three cycles, wrapping register indices and both test-bit polarities cover the off-by-one paths.

// File: rtl/ffld_seq.sv
module ffld_seq #(
  parameter int NREG  = 128,
  parameter int XLEN  = 64,
  parameter int OFF_W = 16,
  localparam int RI_W = $clog2(NREG),
  localparam int VL_W = RI_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [RI_W-1:0] start_ra,
  input  logic [RI_W-1:0] start_rt,
  input  logic [OFF_W-1:0] start_off,
  input  logic [VL_W-1:0] start_vl,
  input  logic            start_rc,
  input  logic            start_vli,
  input  logic            start_tbit,
  output logic [RI_W-1:0] rf_rd_addr,
  input  logic [XLEN-1:0] rf_rd_data,
  output logic            rf_wr_en,
  output logic [RI_W-1:0] rf_wr_addr,
  output logic [XLEN-1:0] rf_wr_data,
  output logic            mem_req,
  output logic [XLEN-1:0] mem_addr,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_data,
  output logic            cr_wr_en,
  output logic [RI_W-1:0] cr_wr_idx,
  output logic [3:0]      cr_wr_val,
  output logic            done,
  output logic [VL_W-1:0] done_vl
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;

  st_t              st;
  logic [RI_W-1:0]  ra_q, rt_q;
  logic [OFF_W-1:0] off_q;
  logic [VL_W-1:0]  vl_q, idx_q;
  logic             rc_q, vli_q, tbit_q;

  logic take, lt, eq, gt, hit, last;

  assign rf_rd_addr = ra_q + idx_q[RI_W-1:0];
  assign mem_addr   = rf_rd_data + {{(XLEN-OFF_W){off_q[OFF_W-1]}}, off_q};
  assign mem_req    = (st == S_ISSUE);

  assign take       = (st == S_WAIT) && mem_rsp_valid;
  assign rf_wr_en   = take;
  assign rf_wr_addr = rt_q + idx_q[RI_W-1:0];
  assign rf_wr_data = mem_rsp_data;

  assign lt = mem_rsp_data[XLEN-1];
  assign eq = (mem_rsp_data == '0);
  assign gt = !lt && !eq;
  assign cr_wr_en  = take && rc_q;
  assign cr_wr_idx = idx_q[RI_W-1:0];
  assign cr_wr_val = {lt, gt, eq, 1'b0};

  assign hit  = (eq == tbit_q);
  assign last = ((idx_q + VL_W'(1)) == vl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ra_q    <= '0;
      rt_q    <= '0;
      off_q   <= '0;
      vl_q    <= '0;
      idx_q   <= '0;
      rc_q    <= 1'b0;
      vli_q   <= 1'b0;
      tbit_q  <= 1'b0;
      done    <= 1'b0;
      done_vl <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          ra_q   <= start_ra;
          rt_q   <= start_rt;
          off_q  <= start_off;
          vl_q   <= start_vl;
          rc_q   <= start_rc;
          vli_q  <= start_vli;
          tbit_q <= start_tbit;
          idx_q  <= '0;
          if (start_vl == '0) begin
            done    <= 1'b1;
            done_vl <= '0;
          end else begin
            st <= S_ISSUE;
          end
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (hit) begin
            done    <= 1'b1;
            done_vl <= vli_q ? idx_q + VL_W'(1) : idx_q;
            st      <= S_IDLE;
          end else if (last) begin
            done    <= 1'b1;
            done_vl <= vl_q;
            st      <= S_IDLE;
          end else begin
            idx_q <= idx_q + VL_W'(1);
            st    <= S_ISSUE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4
  a_r4_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R5
  a_r5_cr_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    cr_wr_en |-> rf_wr_en);

  // R6
  a_r6_vl_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_vl <= vl_q));

  // R10
  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  // R10
  a_r10_done_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && (vl_q != '0)) |-> $past(rf_wr_en));

endmodule

// File: tb/ffld_seq_tb.sv
module ffld_seq_tb;

  localparam int NT = 8;
  localparam int T_VL   [NT] = '{4, 6, 6, 5, 5, 3, 3, 8};
  localparam int T_MT   [NT] = '{-1, 2, 2, 0, 0, 2, 2, -1};
  localparam int T_RC   [NT] = '{1, 1, 1, 0, 1, 0, 1, 1};
  localparam int T_VLI  [NT] = '{0, 1, 0, 0, 1, 1, 0, 1};
  localparam int T_TB   [NT] = '{1, 1, 1, 1, 0, 1, 1, 0};
  localparam int T_LAT  [NT] = '{0, 1, 2, 0, 1, 0, 3, 3};
  localparam int T_RA   [NT] = '{3, 10, 10, 50, 7, 126, 125, 0};
  localparam int T_RT   [NT] = '{40, 20, 90, 60, 8, 127, 126, 64};
  localparam int T_OFF  [NT] = '{8, -16, 24, 0, 4, 0, 32767, -32768};

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic        start = 0;
  logic [6:0]  start_ra = 0, start_rt = 0;
  logic [15:0] start_off = 0;
  logic [7:0]  start_vl = 0;
  logic        start_rc = 0, start_vli = 0, start_tbit = 0;
  logic [6:0]  rf_rd_addr, rf_wr_addr, cr_wr_idx;
  logic [63:0] rf_rd_data, rf_wr_data, mem_addr;
  logic [63:0] mem_rsp_data = 0;
  logic        mem_rsp_valid = 0;
  logic        rf_wr_en, mem_req, cr_wr_en, done;
  logic [3:0]  cr_wr_val;
  logic [7:0]  done_vl;

  ffld_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ra(start_ra), .start_rt(start_rt),
    .start_off(start_off), .start_vl(start_vl), .start_rc(start_rc), .start_vli(start_vli),
    .start_tbit(start_tbit), .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .cr_wr_en(cr_wr_en), .cr_wr_idx(cr_wr_idx),
    .cr_wr_val(cr_wr_val), .done(done), .done_vl(done_vl));

  int checks = 0, fails = 0;
  int nreq = 0, nrsp = 0, nwr = 0, ndone = 0, wcnt = 0;
  int b_req = 0, b_rsp = 0, b_wr = 0;
  int c_ra = 0, c_rt = 0, c_off = 0, c_rc = 0, c_mt = -1, c_tb = 1, c_lat = 0;
  int c_expvl = 0;
  logic prev_done = 0;

  function automatic logic [63:0] rfval(int j);
    return 64'h1000_0000 + 64'(j) * 64'h100;
  endfunction

  assign rf_rd_data = rfval(int'(rf_rd_addr));

  function automatic logic [63:0] gdata(int k);
    logic z;
    z = (k == c_mt) ? c_tb[0] : !c_tb[0];
    if (z) return 64'd0;
    if (k % 2 == 1) return -64'(k + 5);
    return 64'(k * 1000 + 7);
  endfunction

  function automatic logic [3:0] gcr(logic [63:0] d);
    return {d[63], !d[63] && d != 0, d == 0, 1'b0};
  endfunction

  task automatic chk(logic ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) begin
        automatic int k = nreq - b_req;
        automatic logic [63:0] ea = rfval((c_ra + k) % 128) + 64'(signed'(16'(c_off)));
        chk(nreq == nrsp, "R4 outstanding", 64'(nreq - nrsp), 0);
        chk(mem_addr == ea, "R2 address", mem_addr, ea);
        nreq++;
      end
      if (rf_wr_en) begin
        automatic int w = nwr - b_wr;
        automatic logic [63:0] d = gdata(w);
        chk(rf_wr_addr == 7'((c_rt + w) % 128), "R3 wr addr", 64'(rf_wr_addr), 64'((c_rt + w) % 128));
        chk(rf_wr_data == d, "R3 wr data", rf_wr_data, d);
        chk(cr_wr_en == c_rc[0], "R5 cr enable", 64'(cr_wr_en), 64'(c_rc));
        if (cr_wr_en) begin
          chk(cr_wr_val == gcr(d), "R5 cr value", 64'(cr_wr_val), 64'(gcr(d)));
          chk(cr_wr_idx == 7'(w), "R5 cr index", 64'(cr_wr_idx), 64'(w));
        end
        nwr++;
      end else begin
        if (cr_wr_en) chk(0, "R5 cr without write", 1, 0);
      end
      if (done) begin
        chk(done_vl == 8'(c_expvl), "R6 R7 done_vl", 64'(done_vl), 64'(c_expvl));
        ndone++;
      end
      if (done && prev_done) chk(0, "R10 done pulse", 1, 0);
      prev_done <= done;
    end
  end

  always @(posedge clk) begin
    #1;
    mem_rsp_valid = 0;
    if (nreq > nrsp) begin
      if (wcnt >= c_lat) begin
        mem_rsp_valid = 1;
        mem_rsp_data = gdata(nrsp - b_rsp);
        nrsp++;
        wcnt = 0;
      end else wcnt++;
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", wd);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic setup(int vl, int mt, int rc, int vli, int tb, int lat, int ra, int rt, int off);
    b_req = nreq; b_rsp = nrsp; b_wr = nwr;
    c_ra = ra; c_rt = rt; c_off = off; c_rc = rc; c_mt = mt; c_tb = tb; c_lat = lat;
    if (mt < 0 || mt >= vl) c_expvl = vl;
    else c_expvl = vli ? mt + 1 : mt;
    start_vl = 8'(vl); start_rc = rc[0]; start_vli = vli[0]; start_tbit = tb[0];
    start_ra = 7'(ra); start_rt = 7'(rt); start_off = 16'(off);
  endtask

  task automatic wait_done(string tag);
    int d0, n;
    d0 = ndone; n = 0;
    while (ndone == d0 && n < 400) begin @(negedge clk); n++; end
    chk(ndone != d0, tag, 0, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_vec(int vl, int mt, int rc, int vli, int tb, int lat, int ra, int rt, int off, string tag);
    int nl;
    setup(vl, mt, rc, vli, tb, lat, ra, rt, off);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    wait_done(tag);
    nl = (mt < 0 || mt >= vl) ? vl : mt + 1;
    chk(nreq - b_req == nl, "R6 R7 load count", 64'(nreq - b_req), 64'(nl));
    chk(nwr - b_wr == nl, "R3 write count", 64'(nwr - b_wr), 64'(nl));
  endtask

  initial begin
    #1;
    chk(done == 0 && mem_req == 0 && rf_wr_en == 0 && cr_wr_en == 0, "R1 reset", 64'({done, mem_req, rf_wr_en, cr_wr_en}), 0);
    repeat (3) @(negedge clk);
    chk(done == 0 && mem_req == 0 && rf_wr_en == 0 && cr_wr_en == 0, "R1 reset held", 64'({done, mem_req, rf_wr_en, cr_wr_en}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int t = 0; t < NT; t++)
      run_vec(T_VL[t], T_MT[t], T_RC[t], T_VLI[t], T_TB[t], T_LAT[t], T_RA[t], T_RT[t], T_OFF[t], "R6 R7 R10 done seen");

    // R8: zero length
    setup(0, -1, 1, 1, 1, 0, 5, 6, 0);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(done == 1, "R8 done next cycle", 64'(done), 1);
    chk(done_vl == 0, "R8 done_vl", 64'(done_vl), 0);
    @(negedge clk);
    chk(done == 0, "R10 done one cycle", 64'(done), 0);
    repeat (3) @(negedge clk);
    chk(nreq == b_req && nwr == b_wr, "R8 no access", 64'(nreq - b_req + nwr - b_wr), 0);

    // R9: second start while busy is ignored
    setup(4, 3, 1, 0, 1, 3, 20, 30, 16);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (2) @(negedge clk);
    start_vl = 8'd1; start_ra = 7'd99; start_rt = 7'd1; start_vli = 1;
    start = 1;
    @(negedge clk); start = 0;
    start_vl = 8'd4; start_ra = 7'd20; start_rt = 7'd30; start_vli = 0;
    wait_done("R9 done seen");
    chk(nreq - b_req == 4, "R9 ignored start load count", 64'(nreq - b_req), 4);

    // R6: test bit 0, last element exclusive
    run_vec(2, 1, 1, 0, 0, 0, 127, 0, -8, "R6 tbit0 done seen");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule